// File: doc/BRIEF.md
# Element step sequencer

This block keeps the four per-element loop counters of a vector execution state: the source element step, the destination element step, and one sub-element step for each side. A single command port, qualified by a 7-bit immediate, either advances all four counters to the next element, returns one of the current steps, or loads the two loop-order bits. A zero-extended 64-bit result and a 4-bit condition field come out one cycle after each command.

Each side nests its element loop and its sub-element loop on its own. By default the sub-element loop is the inner loop. A per-side order bit (pack for the source side, unpack for the destination side) makes the element loop the inner loop instead. When the vertical-first flag is clear, an automatic advance strobe from the issue logic also moves the counters. When the flag is set, only an explicit step command can change them.

Top module: `elem_step_seq`

## Requirements
- R1: After reset all four counters, both order bits, `resValid` and `crValid` are zero.
- R2: A step command (immediate 0) with the order bit clear advances that side's sub-step first. When the sub-step has reached the last sub-index, it returns to 0 and the element step increments.
- R3: With the pack bit set, the source side advances its element step first. When the element step reaches VL-1, it returns to 0 and the source sub-step increments.
- R4: With the unpack bit set, the destination side uses the swapped order described in R3. The source side's order is not affected.
- R5: `subvlCode` value c (0 to 3) gives c+1 sub-elements, so the last sub-index is c.
- R6: If a step would move either side past its last element, all four counters become 0 and end-of-vector is flagged. The result is then 0 and `crBits` = {LT,GT,EQ,SO} = 4'b0010. A step that does not wrap gives `crBits` = 4'b0100 and a result equal to the new source step.
- R7: With VL = 0, a step command leaves all counters at 0 and flags end-of-vector (`crBits` = 4'b0010).
- R8: Immediate 5 returns the source step and immediate 6 returns the destination step, zero-extended, as they were before the command. The counters do not change. `resValid` is high in the cycle after every command.
- R9: An immediate whose bits [3:2] are both 1 loads pack from bit 1 and unpack from bit 0. Bits [6:4] are ignored. The result is {pack,unpack} in bits [1:0], and all other result bits are zero.
- R10: While `vertFirst` is high, `autoStep` has no effect. While it is low, `autoStep` advances the counters as a step command would, without producing a result.
- R11: When a command and `autoStep` arrive in the same cycle, only the command acts. The counters move at most one step.
- R12: Any other immediate changes no state. It returns result 0 with `crBits` = 4'b0010.
- R13: `crValid` is high in the cycle after a command only when `rcEn` was high with that command. For the non-step commands, `crBits` reports GT when the result is non-zero and EQ when it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdImm | input | 7 | Command immediate (mode selector) |
| rcEn | input | 1 | Request condition field update |
| autoStep | input | 1 | Automatic advance from issue logic |
| vertFirst | input | 1 | Vertical-first mode flag |
| vecLen | input | 7 | Vector length VL |
| subvlCode | input | 2 | Sub-vector length code (count minus one) |
| srcStep | output | 7 | Source element step |
| dstStep | output | 7 | Destination element step |
| srcSub | output | 2 | Source sub-step |
| dstSub | output | 2 | Destination sub-step |
| packMode | output | 1 | Source loop order swapped |
| unpackMode | output | 1 | Destination loop order swapped |
| resValid | output | 1 | Result valid, one cycle after a command |
| resData | output | 64 | Zero-extended result |
| crValid | output | 1 | Condition field valid |
| crBits | output | 4 | {LT,GT,EQ,SO} |

## Verification
An explicit command and the automatic advance strobe can both arrive in one cycle. In that case the command must be the only thing that takes effect. The bench provokes this collision directly, and also at random: random command traffic is mixed with a random `autoStep` while `vertFirst` toggles. Each case is judged through the counter outputs and the result against a reference model that applies only the command. A second case is a mode 12-15 command that swaps the loop order partway through a loop. The bench checks that later steps follow the new order from the counters' current position.

// File: rtl/esq_pkg.sv
package esq_pkg;
  localparam int STEP_W = 7;
  localparam int SUB_W  = 2;
  localparam int RES_W  = 64;

  // strobes from decode to datapath
  typedef struct packed {
    logic doStep;
    logic doPack;
    logic rdSrc;
    logic rdDst;
    logic rdNone;
    logic autoAdv;
    logic rcReq;
    logic newPack;
    logic newUnpack;
  } strobe_t;
endpackage

// File: rtl/esq_ctrl.sv
module esq_ctrl
  import esq_pkg::*;
#(
  parameter int IMM_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [IMM_W-1:0] cmdImm,
  input  logic             rcEn,
  input  logic             autoStep,
  input  logic             vertFirst,
  output strobe_t          st
);
  localparam logic [IMM_W-1:0] ImmStep = '0;
  localparam logic [IMM_W-1:0] ImmSrc  = IMM_W'(5);
  localparam logic [IMM_W-1:0] ImmDst  = IMM_W'(6);

  logic isPackCmd;
  assign isPackCmd = (cmdImm[3:2] == 2'b11);

  always_comb begin
    st           = '0;
    st.doPack    = cmdValid && isPackCmd;
    st.doStep    = cmdValid && !isPackCmd && (cmdImm == ImmStep);
    st.rdSrc     = cmdValid && !isPackCmd && (cmdImm == ImmSrc);
    st.rdDst     = cmdValid && !isPackCmd && (cmdImm == ImmDst);
    st.rdNone    = cmdValid && !isPackCmd && (cmdImm != ImmStep)
                   && (cmdImm != ImmSrc) && (cmdImm != ImmDst);
    // R11: command wins over the automatic advance
    st.autoAdv   = !cmdValid && autoStep && !vertFirst;
    st.rcReq     = cmdValid && rcEn;
    st.newPack   = cmdImm[1];
    st.newUnpack = cmdImm[0];
  end

  // R11
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st.doStep, st.doPack, st.rdSrc, st.rdDst, st.rdNone, st.autoAdv}));
endmodule

// File: rtl/esq_side.sv
module esq_side #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              clearAll,
  input  logic [STEP_W-1:0] vl,
  input  logic [SUB_W-1:0]  subLast,
  input  logic              swapOrder,
  output logic [STEP_W-1:0] step,
  output logic [STEP_W-1:0] stepNext,
  output logic [SUB_W-1:0]  sub,
  output logic              wrap
);
  logic              atLastStep, atLastSub;
  logic [SUB_W-1:0]  subNext;

  assign atLastStep = ({1'b0, step} + 1'b1) >= {1'b0, vl};
  assign atLastSub  = (sub >= subLast);
  assign wrap       = atLastStep && atLastSub;

  always_comb begin
    stepNext = step;
    subNext  = sub;
    if (!swapOrder) begin
      // sub-element loop inner
      if (!atLastSub) subNext = sub + 1'b1;
      else begin
        subNext  = '0;
        stepNext = step + 1'b1;
      end
    end else begin
      // element loop inner
      if (!atLastStep) stepNext = step + 1'b1;
      else begin
        stepNext = '0;
        subNext  = sub + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
      sub  <= '0;
    end else if (adv) begin
      if (clearAll) begin
        step <= '0;
        sub  <= '0;
      end else begin
        step <= stepNext;
        sub  <= subNext;
      end
    end
  end

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && clearAll |=> step == '0 && sub == '0);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(step) && $stable(sub));
endmodule

// File: rtl/esq_dp.sv
module esq_dp
  import esq_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int RES_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  logic [STEP_W-1:0] vl,
  input  logic [SUB_W-1:0]  subvlCode,
  output logic [STEP_W-1:0] srcStep,
  output logic [STEP_W-1:0] dstStep,
  output logic [SUB_W-1:0]  srcSub,
  output logic [SUB_W-1:0]  dstSub,
  output logic              packMode,
  output logic              unpackMode,
  output logic              resValid,
  output logic [RES_W-1:0]  resData,
  output logic              crValid,
  output logic [3:0]        crBits
);
  localparam int NSIDE = 2;  // 0 = source, 1 = destination

  logic [STEP_W-1:0] stepQ [NSIDE];
  logic [STEP_W-1:0] stepN [NSIDE];
  logic [SUB_W-1:0]  subQ  [NSIDE];
  logic              wrapA [NSIDE];
  logic              swapA [NSIDE];
  logic              packQ, unpackQ, advAny, eov;
  logic [STEP_W-1:0] resNxt;

  assign swapA[0] = packQ;
  assign swapA[1] = unpackQ;
  assign advAny   = st.doStep || st.autoAdv;
  assign eov      = (vl == '0) || wrapA[0] || wrapA[1];

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    esq_side #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (advAny),
      .clearAll (eov),
      .vl       (vl),
      .subLast  (subvlCode),
      .swapOrder(swapA[g]),
      .step     (stepQ[g]),
      .stepNext (stepN[g]),
      .sub      (subQ[g]),
      .wrap     (wrapA[g])
    );
  end

  always_comb begin
    resNxt = '0;
    if (st.doStep)     resNxt = eov ? '0 : stepN[0];
    else if (st.rdSrc) resNxt = stepQ[0];
    else if (st.rdDst) resNxt = stepQ[1];
    else if (st.doPack) resNxt = STEP_W'({st.newPack, st.newUnpack});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      packQ    <= 1'b0;
      unpackQ  <= 1'b0;
      resValid <= 1'b0;
      resData  <= '0;
      crValid  <= 1'b0;
      crBits   <= '0;
    end else begin
      resValid <= st.doStep || st.doPack || st.rdSrc || st.rdDst || st.rdNone;
      crValid  <= st.rcReq;
      if (st.doPack) begin
        packQ   <= st.newPack;
        unpackQ <= st.newUnpack;
      end
      if (st.doStep || st.doPack || st.rdSrc || st.rdDst || st.rdNone) begin
        resData <= {{(RES_W-STEP_W){1'b0}}, resNxt};
        if (st.doStep) crBits <= {1'b0, !eov, eov, 1'b0};
        else           crBits <= {1'b0, resNxt != '0, resNxt == '0, 1'b0};
      end
    end
  end

  assign srcStep    = stepQ[0];
  assign dstStep    = stepQ[1];
  assign srcSub     = subQ[0];
  assign dstSub     = subQ[1];
  assign packMode   = packQ;
  assign unpackMode = unpackQ;

  // R6
  eov_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.doStep && eov |=> crBits == 4'b0010 && srcStep == '0 && dstStep == '0);
  // R9
  pack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.doPack |=> packQ == $past(st.newPack) && unpackQ == $past(st.newUnpack));
  // R13
  cr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st.rcReq |=> !crValid);
endmodule

// File: rtl/elem_step_seq.sv
module elem_step_seq
  import esq_pkg::*;
#(
  parameter int STEP_W = esq_pkg::STEP_W,
  parameter int SUB_W  = esq_pkg::SUB_W,
  parameter int RES_W  = esq_pkg::RES_W,
  parameter int IMM_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic [IMM_W-1:0]  cmdImm,
  input  logic              rcEn,
  input  logic              autoStep,
  input  logic              vertFirst,
  input  logic [STEP_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subvlCode,
  output logic [STEP_W-1:0] srcStep,
  output logic [STEP_W-1:0] dstStep,
  output logic [SUB_W-1:0]  srcSub,
  output logic [SUB_W-1:0]  dstSub,
  output logic              packMode,
  output logic              unpackMode,
  output logic              resValid,
  output logic [RES_W-1:0]  resData,
  output logic              crValid,
  output logic [3:0]        crBits
);
  strobe_t st;

  esq_ctrl #(.IMM_W(IMM_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdImm(cmdImm),
    .rcEn(rcEn), .autoStep(autoStep), .vertFirst(vertFirst), .st(st)
  );

  esq_dp #(.STEP_W(STEP_W), .SUB_W(SUB_W), .RES_W(RES_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .vl(vecLen), .subvlCode(subvlCode),
    .srcStep(srcStep), .dstStep(dstStep), .srcSub(srcSub), .dstSub(dstSub),
    .packMode(packMode), .unpackMode(unpackMode), .resValid(resValid),
    .resData(resData), .crValid(crValid), .crBits(crBits)
  );
endmodule

// File: tb/elem_step_seq_tb_top.sv
module elem_step_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [6:0]  cmdImm = '0;
  logic        rcEn = 1'b0;
  logic        autoStep = 1'b0;
  logic        vertFirst = 1'b0;
  logic [6:0]  vecLen = '0;
  logic [1:0]  subvlCode = '0;
  logic [6:0]  srcStep, dstStep;
  logic [1:0]  srcSub, dstSub;
  logic        packMode, unpackMode, resValid, crValid;
  logic [63:0] resData;
  logic [3:0]  crBits;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int mSrc, mDst, mSS, mDS;
  bit mPack, mUnp;

  always #2 clk = ~clk;

  elem_step_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdImm(cmdImm), .rcEn(rcEn),
    .autoStep(autoStep), .vertFirst(vertFirst), .vecLen(vecLen), .subvlCode(subvlCode),
    .srcStep(srcStep), .dstStep(dstStep), .srcSub(srcSub), .dstSub(dstSub),
    .packMode(packMode), .unpackMode(unpackMode), .resValid(resValid),
    .resData(resData), .crValid(crValid), .crBits(crBits)
  );

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit sideWrap(int st, int sb, int vl, int last);
    return (st + 1 >= vl) && (sb >= last);
  endfunction

  task automatic sideNext(inout int st, inout int sb, input int vl, input int last, input bit swp);
    if (!swp) begin
      if (sb < last) sb++;
      else begin sb = 0; st = (st + 1) % 128; end
    end else begin
      if (st + 1 < vl) st++;
      else begin st = 0; sb = (sb + 1) % 4; end
    end
  endtask

  task automatic modelStep(input int vl, input int last, output bit eov);
    eov = (vl == 0) || sideWrap(mSrc, mSS, vl, last) || sideWrap(mDst, mDS, vl, last);
    if (eov) begin mSrc = 0; mDst = 0; mSS = 0; mDS = 0; end
    else begin
      sideNext(mSrc, mSS, vl, last, mPack);
      sideNext(mDst, mDS, vl, last, mUnp);
    end
  endtask

  task automatic drive(bit cv, logic [6:0] imm, bit rc, bit au, bit vf, int vl, int code);
    bit eov, isPack;
    string ctx, sTag, dTag;
    longint unsigned eRes;
    logic [3:0] eCr;
    @(negedge clk);
    cmdValid = cv; cmdImm = imm; rcEn = rc; autoStep = au; vertFirst = vf;
    vecLen = 7'(vl); subvlCode = 2'(code);
    isPack = (imm[3:2] == 2'b11);
    eRes = 0; eCr = 4'b0010; ctx = "R12";
    if (cv) begin
      if (isPack) begin
        mPack = imm[1]; mUnp = imm[0];
        eRes = {mPack, mUnp}; ctx = "R9";
        eCr = (eRes != 0) ? 4'b0100 : 4'b0010;
      end else if (imm == 0) begin
        modelStep(vl, code, eov);
        eRes = mSrc; eCr = eov ? 4'b0010 : 4'b0100;
        ctx = (vl == 0) ? "R7" : "R6";
      end else if (imm == 5 || imm == 6) begin
        eRes = (imm == 5) ? mSrc : mDst; ctx = "R8";
        eCr = (eRes != 0) ? 4'b0100 : 4'b0010;
      end
      if (au) ctx = {ctx, "/R11"};
    end else if (au && !vf) begin
      modelStep(vl, code, eov); ctx = "R10 horizontal";
    end else ctx = "R10 idle";
    sTag = mPack ? "R3" : (code != 0 ? "R5" : "R2");
    dTag = mUnp ? "R4" : (code != 0 ? "R5" : "R2");
    @(posedge clk); #1;
    chk($sformatf("%s/%s srcStep", ctx, sTag), srcStep, mSrc);
    chk($sformatf("%s/%s srcSub", ctx, sTag), srcSub, mSS);
    chk($sformatf("%s/%s dstStep", ctx, dTag), dstStep, mDst);
    chk($sformatf("%s/%s dstSub", ctx, dTag), dstSub, mDS);
    chk("R9 pack bits", {packMode, unpackMode}, {mPack, mUnp});
    chk("R8 resValid", resValid, cv);
    chk("R13 crValid", crValid, cv && rc);
    if (cv) begin
      chk($sformatf("%s result", ctx), resData, eRes);
      if (rc) chk($sformatf("%s/R13 crBits", ctx), crBits, eCr);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mSrc = 0; mDst = 0; mSS = 0; mDS = 0; mPack = 0; mUnp = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 srcStep", srcStep, 0);
    chk("R1 dstStep", dstStep, 0);
    chk("R1 subs", {srcSub, dstSub}, 0);
    chk("R1 pack bits", {packMode, unpackMode}, 0);
    chk("R1 valids", {resValid, crValid}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 / R5 / R6: VL=3, two sub-elements, full loop and wrap
    for (int i = 0; i < 7; i++) drive(1, 7'd0, 1, 0, 1, 3, 1);
    // R8 queries
    drive(1, 7'd0, 1, 0, 1, 4, 0);
    drive(1, 7'd5, 1, 0, 1, 4, 0);
    drive(1, 7'd6, 1, 0, 1, 4, 0);
    // R9 pack only, upper bits set (ignored)
    drive(1, 7'b1111110, 1, 0, 1, 4, 0);
    // R3: source order swapped
    for (int i = 0; i < 9; i++) drive(1, 7'd0, 1, 0, 1, 2, 2);
    // R4: unpack only, then swap mid-loop
    drive(1, 7'b0001101, 1, 0, 1, 3, 1);
    for (int i = 0; i < 4; i++) drive(1, 7'd0, 1, 0, 1, 3, 1);
    drive(1, 7'b0001110, 0, 0, 1, 3, 1);
    for (int i = 0; i < 4; i++) drive(1, 7'd0, 1, 0, 1, 3, 1);
    drive(1, 7'b0001100, 1, 0, 1, 3, 1);
    // R7: VL zero
    drive(1, 7'd0, 1, 0, 1, 0, 3);
    drive(1, 7'd0, 1, 0, 1, 0, 0);
    // R10: vertical-first ignores autoStep, horizontal follows it
    for (int i = 0; i < 3; i++) drive(0, 7'd0, 0, 1, 1, 5, 0);
    for (int i = 0; i < 3; i++) drive(0, 7'd0, 0, 1, 0, 5, 0);
    // R11: collision of command and autoStep
    drive(1, 7'd0, 1, 1, 0, 5, 0);
    drive(1, 7'd5, 1, 1, 0, 5, 0);
    // R12: other modes
    drive(1, 7'd1, 1, 0, 0, 5, 0);
    drive(1, 7'd7, 1, 0, 0, 5, 0);
    drive(1, 7'd19, 1, 0, 0, 5, 0);
    // R13: no condition update without rcEn
    drive(1, 7'd0, 0, 0, 1, 5, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r, vl, code;
      logic [6:0] imm;
      r = $urandom_range(0, 9);
      case (r)
        0, 1, 2, 3: imm = 7'd0;
        4: imm = 7'd5;
        5: imm = 7'd6;
        6: imm = {3'($urandom_range(0, 7)), 2'b11, 2'($urandom_range(0, 3))};
        default: imm = 7'($urandom_range(1, 11));
      endcase
      vl = ($urandom_range(0, 15) == 0) ? 0 : $urandom_range(1, 6);
      code = $urandom_range(0, 3);
      drive($urandom_range(0, 9) < 7, imm, $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 1), vl, code);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule